// File: doc/BRIEF.md
# Raster Display Timing Generator

This block drives the timing side of a raster display of up to 4096 by 4096 pixels. It produces horizontal sync, vertical sync and a data-enable strobe. It also gives the pixel pipeline the column and row of the current pixel inside the visible window, together with a plain in-window flag. A horizontal counter steps once per pixel clock through four phases in fixed order: sync pulse, back porch, visible pixels, front porch. A vertical counter steps through the same four phases, one line at a time.

Software sets up the block through a small write port. Each phase length is written as the wanted count minus one. A polarity word decides, for each of the three strobes, whether that strobe is driven active-high or active-low. A control bit starts and stops the raster. Writes to the lengths and to the polarity go into a pending copy. The generator copies the pending set into its working set only at a frame boundary, so a frame always runs on one consistent set of values. At each frame boundary the block sets a sticky vsync flag. Software clears the flag by writing a one to it, and a mask bit gates the flag onto the interrupt line.

Top module: `rtg_top`

## Requirements
- R1: Every phase length register holds the phase duration minus one, so a value of n gives n+1 pixel clocks (horizontal) or n+1 lines (vertical). The register addresses are: 2 hsync, 3 hback, 4 hactive, 5 hfront, 6 vsync, 7 vback, 8 vactive, 9 vfront.
- R2: Each line runs sync, then back porch, then visible, then front porch. Horizontal sync is active only in the sync phase of the line.
- R3: Each frame runs the same four phases in lines, in the same order. Vertical sync is active only in the vertical sync phase, and data enable is active only where the horizontal and vertical visible phases overlap.
- R4: In the polarity register (address 1), bit 0 controls vsync, bit 1 hsync and bit 2 data enable. A set bit makes that strobe active-high and a clear bit makes it active-low. The register resets to 0.
- R5: Bit 0 of the control register (address 0) enables the generator. While it is 0, every strobe sits at its inactive level, the in-window flag and both coordinates are 0, and the counters are held at the first clock of vertical sync. Enabling starts the raster from that point, with hsync and vsync active in the first output cycle.
- R6: Writes to the length and polarity registers take effect only at the next frame boundary. While the generator is disabled, they take effect at once.
- R7: The sticky vsync flag (interrupt status bit 2, `int_stat_o[2]`) is set on the clock edge that ends the last pixel of a frame. It stays set until it is cleared.
- R8: A write to address 11 with data bit 2 set clears the flag. Bit 2 clear has no effect. If the clear falls on the same edge that sets the flag, the set wins.
- R9: `irq_o` is the flag ANDed with bit 2 of the mask register (address 10).
- R10: While inside the visible window, `px_x_o` and `px_y_o` give the zero-based column and row and `in_win_o` is 1. Outside the window all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word address |
| cfg_wdata_i | input | 12 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| in_win_o | output | 1 | Inside the visible window, always active-high |
| px_x_o | output | 12 | Column inside the window |
| px_y_o | output | 12 | Row inside the window |
| int_stat_o | output | 4 | Interrupt status; bit 2 is the vsync flag |
| irq_o | output | 1 | Masked vsync interrupt |

## Verification
Two pairs of events can land on the same edge. First, the flag set at the end of a frame can coincide with a software clear. The bench issues the clear so that it is registered on exactly the edge that ends a frame, and expects the flag to read 1 afterwards, having already seen it read 0 after an earlier clear. Second, a frame wrap can coincide with a pending write of new timing. The bench writes a new visible width mid-frame and checks two points: a pixel late in the same frame still follows the old width, and a pixel in the next frame has a column that only the new width can produce.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam int NPH = 4;
  localparam int IRQ_BIT = 2;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_POL   = 4'd1;
  localparam logic [AW-1:0] A_HBASE = 4'd2;
  localparam logic [AW-1:0] A_VBASE = 4'd6;
  localparam logic [AW-1:0] A_MASK  = 4'd10;
  localparam logic [AW-1:0] A_CLR   = 4'd11;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [CW-1:0]           wdata_i,
  input  logic                    load_i,
  output logic                    en_o,
  output logic [2:0]              pol_o,
  output logic [NPH-1:0][CW-1:0]  h_len_o,
  output logic [NPH-1:0][CW-1:0]  v_len_o,
  output logic                    mask_o,
  output logic                    clr_o
);
  logic [NPH-1:0][CW-1:0] pend_h, pend_v;
  logic [2:0]             pend_pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_h   <= '0;
      pend_v   <= '0;
      pend_pol <= '0;
      en_o     <= 1'b0;
      mask_o   <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NPH; i++) begin
        if (addr_i == A_HBASE + AW'(i)) pend_h[i] <= wdata_i;
        if (addr_i == A_VBASE + AW'(i)) pend_v[i] <= wdata_i;
      end
      if (addr_i == A_POL)  pend_pol <= wdata_i[2:0];
      if (addr_i == A_CTRL) en_o     <= wdata_i[0];
      if (addr_i == A_MASK) mask_o   <= wdata_i[IRQ_BIT];
    end
  end

  // working copy, refreshed only at frame boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_len_o <= '0;
      v_len_o <= '0;
      pol_o   <= '0;
    end else if (load_i) begin
      h_len_o <= pend_h;
      v_len_o <= pend_v;
      pol_o   <= pend_pol;
    end
  end

  assign clr_o = we_i && (addr_i == A_CLR) && wdata_i[IRQ_BIT];
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   step_i,
  input  logic [NPH-1:0][CW-1:0] len_i,
  output phase_e                 phase_o,
  output logic [CW-1:0]          cnt_o,
  output logic                   wrap_o
);
  logic last;
  assign last   = (cnt_o == len_i[phase_o]);
  assign wrap_o = run_i && step_i && last && (phase_o == PH_FRONT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_SYNC;
      cnt_o   <= '0;
    end else if (!run_i) begin
      phase_o <= PH_SYNC;
      cnt_o   <= '0;
    end else if (step_i) begin
      if (last) begin
        cnt_o   <= '0;
        phase_o <= phase_e'(phase_o + 2'd1);
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o && mask_i;
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [3:0]    cfg_addr_i,
  input  logic [11:0]   cfg_wdata_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          in_win_o,
  output logic [11:0]   px_x_o,
  output logic [11:0]   px_y_o,
  output logic [3:0]    int_stat_o,
  output logic          irq_o
);
  logic                   en, mask, clr, flag, load;
  logic [2:0]             pol;
  logic [NPH-1:0][CW-1:0] h_len, v_len;
  phase_e                 h_ph, v_ph;
  logic [CW-1:0]          h_cnt, v_cnt;
  logic                   h_wrap, frame_end;
  logic                   hs_act, vs_act;

  assign load = !en || frame_end;

  rtg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .load_i(load), .en_o(en), .pol_o(pol),
    .h_len_o(h_len), .v_len_o(v_len), .mask_o(mask), .clr_o(clr)
  );

  rtg_axis u_h (
    .clk_i, .rst_ni, .run_i(en), .step_i(1'b1), .len_i(h_len),
    .phase_o(h_ph), .cnt_o(h_cnt), .wrap_o(h_wrap)
  );

  rtg_axis u_v (
    .clk_i, .rst_ni, .run_i(en), .step_i(h_wrap), .len_i(v_len),
    .phase_o(v_ph), .cnt_o(v_cnt), .wrap_o(frame_end)
  );

  rtg_irq u_irq (
    .clk_i, .rst_ni, .set_i(frame_end), .clr_i(clr), .mask_i(mask),
    .flag_o(flag), .irq_o(irq_o)
  );

  assign in_win_o = en && (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign hs_act   = en && (h_ph == PH_SYNC);
  assign vs_act   = en && (v_ph == PH_SYNC);

  // set polarity bit = active-high
  assign vsync_o = ~(vs_act ^ pol[0]);
  assign hsync_o = ~(hs_act ^ pol[1]);
  assign de_o    = ~(in_win_o ^ pol[2]);

  assign px_x_o = in_win_o ? h_cnt : '0;
  assign px_y_o = in_win_o ? v_cnt : '0;

  assign int_stat_o = {1'b0, flag, 2'b00};
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en,
  input logic        frame_end,
  input logic        clr,
  input logic        flag,
  input logic        mask,
  input logic        irq_o,
  input logic        hsync_o,
  input logic        hpol,
  input logic        in_win_o,
  input logic [11:0] px_x_o,
  input logic [11:0] hact_len,
  input logic [2:0]  pol
);
  p_x_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win_o |-> px_x_o <= hact_len);

  p_no_hs_in_win_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win_o |-> hsync_o == !hpol);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !in_win_o && px_x_o == 12'd0);

  p_pol_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !frame_end |=> $stable(pol));

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> flag);

  p_flag_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !frame_end |=> !flag);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag && mask);
endmodule

bind rtg_top rtg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en), .frame_end(frame_end),
  .clr(clr), .flag(flag), .mask(mask), .irq_o(irq_o),
  .hsync_o(hsync_o), .hpol(pol[1]), .in_win_o(in_win_o),
  .px_x_o(px_x_o), .hact_len(h_len[2]), .pol(pol)
);

// File: tb/rtg_top_bench.sv
module rtg_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic        hs, vs, de, win, irq;
  logic [11:0] x, y;
  logic [3:0]  stat;
  int          checks = 0, fails = 0, t = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  rtg_top u_rtg_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .in_win_o(win), .px_x_o(x), .px_y_o(y), .int_stat_o(stat), .irq_o(irq)
  );

  // line 8 clocks (2 sync,1 back,4 act,1 front); frame 5 lines (1,1,2,1)
  localparam int NV = 13;
  localparam int VT [NV]  = '{0, 2, 8, 16, 19, 22, 23, 28, 30, 32, 39, 40, 59};
  localparam int VHS[NV]  = '{1, 0, 1, 1,  0,  0,  0,  0,  0,  1,  0,  1,  0};
  localparam int VVS[NV]  = '{1, 1, 0, 0,  0,  0,  0,  0,  0,  0,  0,  1,  0};
  localparam int VDE[NV]  = '{0, 0, 0, 0,  1,  1,  0,  1,  1,  0,  0,  0,  1};
  localparam int VX [NV]  = '{0, 0, 0, 0,  0,  3,  0,  1,  3,  0,  0,  0,  0};
  localparam int VY [NV]  = '{0, 0, 0, 0,  0,  0,  0,  1,  1,  0,  0,  0,  0};
  localparam int VF [NV]  = '{0, 0, 0, 0,  0,  0,  0,  0,  0,  0,  0,  1,  1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    we = 1'b1; addr = a; wdata = 12'(d);
    step(1);
    we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    // reset: disabled, polarity 0 -> inactive high
    chk("R4 reset hs", hs, 1);
    chk("R4 reset vs", vs, 1);
    chk("R5 reset de", de, 1);
    chk("R5 reset win", win, 0);
    chk("R10 reset x", x, 0);
    chk("R7 reset flag", stat[2], 0);
    chk("R9 reset irq", irq, 0);

    wr(4'd1, 7);
    wr(4'd2, 1); wr(4'd3, 0); wr(4'd4, 3); wr(4'd5, 0);
    wr(4'd6, 0); wr(4'd7, 0); wr(4'd8, 1); wr(4'd9, 0);
    wr(4'd0, 1);
    t = 0;
    for (int i = 0; i < NV; i++) begin
      step(VT[i] - t);
      chk("R2 hsync", hs, VHS[i]);
      chk("R3 vsync", vs, VVS[i]);
      chk("R3 de", de, VDE[i]);
      chk("R10 win", win, VDE[i]);
      chk("R1 R10 x", x, VX[i]);
      chk("R10 y", y, VY[i]);
      chk("R7 flag", stat[2], VF[i]);
    end

    chk("R9 masked irq", irq, 0);
    wr(4'd10, 4);
    chk("R9 unmasked irq", irq, 1);
    wr(4'd11, 0);
    chk("R8 clear bit2=0 ignored", stat[2], 1);
    wr(4'd11, 4);
    chk("R8 clear", stat[2], 0);
    chk("R9 irq after clear", irq, 0);

    step(79 - t);
    wr(4'd11, 4);
    chk("R8 set wins over clear", stat[2], 1);

    step(85 - t);
    wr(4'd4, 7);
    step(99 - t);
    chk("R6 old width de", de, 1);
    chk("R6 old width x", x, 0);
    step(154 - t);
    chk("R6 new width de", de, 1);
    chk("R6 new width x", x, 7);
    chk("R6 new width y", y, 0);

    step(160 - t);
    wr(4'd0, 0);
    chk("R5 off hs", hs, 0);
    chk("R5 off vs", vs, 0);
    chk("R5 off de", de, 0);
    chk("R5 off win", win, 0);
    chk("R5 off y", y, 0);

    wr(4'd1, 0);
    wr(4'd0, 1);
    t = 0;
    chk("R4 R5 restart hs low", hs, 0);
    chk("R4 R5 restart vs low", vs, 0);
    chk("R4 de inactive high", de, 1);
    step(27);
    chk("R4 de active low", de, 0);
    chk("R4 hs inactive high", hs, 1);
    chk("R10 win", win, 1);
    chk("R10 x", x, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired t=%0d", t);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule